// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block derives the horizontal and vertical control strobes that a panel driver expects from a single pixel clock. A horizontal counter sweeps a programmable line period and a line counter sweeps a programmable frame period. Decoders compare the two counts against a small register file and produce:

- two one-clock horizontal start strobes;
- four line-load windows;
- three frame windows, two of which can be merged with a line-load window;
- an active-image enable.

Each strobe has its own polarity. All strobes leave the block through a register. A control bit chooses whether they change on the rising edge of the pixel clock or half a cycle later, on the falling edge.

Software programs the block through a plain write port and a registered read port. There is no streaming data path, so every pin is a plain control pin with no handshake. The counters keep running while registers are written. A new value takes effect at the clock edge that follows the write.

Top module: `lcd_timing_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register at `wr_addr` on the rising edge. `rd_data` shows, one edge after `rd_addr` is presented, the register contents as they stood before that edge. Unmapped addresses read 0 and writes to them are dropped. The map is:
  - 0: control, bit0 = edge select, bit1 = AND merge, bit2 = OR merge.
  - 1: line period, 11 bits.
  - 2: frame period, 10 bits.
  - 3, 4: active horizontal start and end.
  - 5, 6: active vertical start and end.
  - 8+i: start strobe i position, with polarity in bit 15.
  - 16+2i: load window i lead, with polarity in bit 15.
  - 17+2i: load window i trail.
  - 32+2i: frame window i lead line, with polarity in bit 15.
  - 33+2i: frame window i trail line.
- R2: The horizontal count advances by one per clock. Once the count is at or above the line period minus 1, it returns to 0 on the next clock. A period of 0 behaves as 2048.
- R3: The line count changes only on a horizontal wrap: it advances by one, or returns to 0 once it is at or above the frame period minus 1. A period of 0 behaves as 1024.
- R4: Each start strobe is active for exactly the count equal to its position.
- R5: Each load window is active while lead <= horizontal count < trail. When trail <= lead the window is never active.
- R6: Each frame window is active for whole lines while lead <= line count < trail. When trail <= lead the window is never active.
- R7: Every polarity bit set to 0 gives active-high, and set to 1 gives active-low.
- R8: With control bit1 set, frame window 1 (index from 0) is the AND of its positive form with the positive form of load window 3. Polarity is applied afterwards.
- R9: With control bit2 set, frame window 2 is the OR of its positive form with the positive form of load window 1. Polarity is applied afterwards.
- R10: `active_o` is high while the horizontal count lies in [start, end) and the line count lies in [start, end).
- R11: Outputs reflect the counts and registers that held just before a rising edge, and they update at that edge. With edge select set, the same values instead appear at the following falling edge.
- R12: Reset clears all registers, both counts, `rd_data` and every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Registered read data |
| hstart_o | output | 2 | Horizontal start strobes |
| hload_o | output | 4 | Line-load windows |
| vframe_o | output | 3 | Frame windows |
| active_o | output | 1 | Active-image enable |

## Verification
The bench builds the block with its default parameters: 11-bit horizontal and 10-bit vertical counts, two start strobes, four load windows and three frame windows. Writing a 20-clock line and a 6-line frame brings many frame wraps within a few hundred clocks. That short frame makes it possible to observe the merge modes, the inverted polarities and an empty window within a short run. The falling-edge mode is exercised as well. Shrinking the line period while a line is in progress exercises the at-or-above wrap rule, and a full address sweep covers readback of mapped and unmapped locations.

// File: rtl/ltg_pkg.sv
package ltg_pkg;
  localparam int DW      = 16;
  localparam int AW      = 6;
  localparam int POL_BIT = 15;

  localparam int ADR_CTRL = 0;
  localparam int ADR_HPER = 1;
  localparam int ADR_VPER = 2;
  localparam int ADR_AHS  = 3;
  localparam int ADR_AHE  = 4;
  localparam int ADR_AVS  = 5;
  localparam int ADR_AVE  = 6;
  localparam int HS_BASE  = 8;
  localparam int LD_BASE  = 16;
  localparam int FR_BASE  = 32;

  // merge pairs (index from 0)
  localparam int AND_FR = 1;
  localparam int AND_LD = 3;
  localparam int OR_FR  = 2;
  localparam int OR_LD  = 1;
endpackage

// File: rtl/ltg_regfile.sv
module ltg_regfile
  import ltg_pkg::*;
#(
  parameter int HW   = 11,
  parameter int VW   = 10,
  parameter int N_HS = 2,
  parameter int N_LD = 4,
  parameter int N_FR = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic                      edge_sel,
  output logic                      and_en,
  output logic                      or_en,
  output logic [HW-1:0]             hper,
  output logic [VW-1:0]             vper,
  output logic [HW-1:0]             act_hs,
  output logic [HW-1:0]             act_he,
  output logic [VW-1:0]             act_vs,
  output logic [VW-1:0]             act_ve,
  output logic [N_HS-1:0][HW-1:0]   hs_pos,
  output logic [N_HS-1:0]           hs_pol,
  output logic [N_LD-1:0][HW-1:0]   ld_lead,
  output logic [N_LD-1:0][HW-1:0]   ld_trail,
  output logic [N_LD-1:0]           ld_pol,
  output logic [N_FR-1:0][VW-1:0]   fr_lead,
  output logic [N_FR-1:0][VW-1:0]   fr_trail,
  output logic [N_FR-1:0]           fr_pol
);

  wire unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel <= 1'b0;
      and_en   <= 1'b0;
      or_en    <= 1'b0;
      hper     <= '0;
      vper     <= '0;
      act_hs   <= '0;
      act_he   <= '0;
      act_vs   <= '0;
      act_ve   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADR_CTRL): begin
          edge_sel <= wr_data[0];
          and_en   <= wr_data[1];
          or_en    <= wr_data[2];
        end
        AW'(ADR_HPER): hper   <= wr_data[HW-1:0];
        AW'(ADR_VPER): vper   <= wr_data[VW-1:0];
        AW'(ADR_AHS):  act_hs <= wr_data[HW-1:0];
        AW'(ADR_AHE):  act_he <= wr_data[HW-1:0];
        AW'(ADR_AVS):  act_vs <= wr_data[VW-1:0];
        AW'(ADR_AVE):  act_ve <= wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_HS; i++) begin : g_hs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_pos[i] <= '0;
        hs_pol[i] <= 1'b0;
      end else if (wr_en && wr_addr == AW'(HS_BASE + i)) begin
        hs_pos[i] <= wr_data[HW-1:0];
        hs_pol[i] <= wr_data[POL_BIT];
      end
    end
  end

  for (genvar i = 0; i < N_LD; i++) begin : g_ld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_lead[i]  <= '0;
        ld_trail[i] <= '0;
        ld_pol[i]   <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == AW'(LD_BASE + 2*i)) begin
          ld_lead[i] <= wr_data[HW-1:0];
          ld_pol[i]  <= wr_data[POL_BIT];
        end
        if (wr_addr == AW'(LD_BASE + 2*i + 1))
          ld_trail[i] <= wr_data[HW-1:0];
      end
    end
  end

  for (genvar i = 0; i < N_FR; i++) begin : g_fr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fr_lead[i]  <= '0;
        fr_trail[i] <= '0;
        fr_pol[i]   <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == AW'(FR_BASE + 2*i)) begin
          fr_lead[i] <= wr_data[VW-1:0];
          fr_pol[i]  <= wr_data[POL_BIT];
        end
        if (wr_addr == AW'(FR_BASE + 2*i + 1))
          fr_trail[i] <= wr_data[VW-1:0];
      end
    end
  end

  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      AW'(ADR_CTRL): rd_next[2:0]    = {or_en, and_en, edge_sel};
      AW'(ADR_HPER): rd_next[HW-1:0] = hper;
      AW'(ADR_VPER): rd_next[VW-1:0] = vper;
      AW'(ADR_AHS):  rd_next[HW-1:0] = act_hs;
      AW'(ADR_AHE):  rd_next[HW-1:0] = act_he;
      AW'(ADR_AVS):  rd_next[VW-1:0] = act_vs;
      AW'(ADR_AVE):  rd_next[VW-1:0] = act_ve;
      default: ;
    endcase
    for (int i = 0; i < N_HS; i++) begin
      if (rd_addr == AW'(HS_BASE + i)) begin
        rd_next[HW-1:0]    = hs_pos[i];
        rd_next[POL_BIT]   = hs_pol[i];
      end
    end
    for (int i = 0; i < N_LD; i++) begin
      if (rd_addr == AW'(LD_BASE + 2*i)) begin
        rd_next[HW-1:0]  = ld_lead[i];
        rd_next[POL_BIT] = ld_pol[i];
      end
      if (rd_addr == AW'(LD_BASE + 2*i + 1))
        rd_next[HW-1:0] = ld_trail[i];
    end
    for (int i = 0; i < N_FR; i++) begin
      if (rd_addr == AW'(FR_BASE + 2*i)) begin
        rd_next[VW-1:0]  = fr_lead[i];
        rd_next[POL_BIT] = fr_pol[i];
      end
      if (rd_addr == AW'(FR_BASE + 2*i + 1))
        rd_next[VW-1:0] = fr_trail[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  // R1: a period write lands on the next edge
  assert_hper_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADR_HPER)) |=> (hper == $past(wr_data[HW-1:0])));

endmodule

// File: rtl/ltg_counters.sv
module ltg_counters #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hper,
  input  logic [VW-1:0] vper,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);

  logic [HW-1:0] hlast;
  logic [VW-1:0] vlast;
  logic          hwrap;
  logic          vwrap;

  assign hlast = hper - 1'b1;
  assign vlast = vper - 1'b1;
  assign hwrap = (hcnt >= hlast);
  assign vwrap = (vcnt >= vlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hwrap) begin
      hcnt <= '0;
      vcnt <= vwrap ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R2: a count at or past the last position returns to zero
  assert_hwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt >= hper - 1'b1) |=> (hcnt == '0));

  // R3: the line count holds between horizontal wraps
  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < hper - 1'b1) |=> $stable(vcnt));

endmodule

// File: rtl/ltg_window.sv
module ltg_window #(
  parameter int W = 11
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lead,
  input  logic [W-1:0] trail,
  output logic         hit
);
  assign hit = (cnt >= lead) && (cnt < trail);
endmodule

// File: rtl/ltg_out_stage.sv
module ltg_out_stage #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_sel,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] rise_q;
  logic [N-1:0] fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rise_q;
  end

  assign q = edge_sel ? fall_q : rise_q;

  // R11: the falling-edge copy has caught up by every rising edge
  assert_fall_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q == rise_q);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import ltg_pkg::*;
#(
  parameter int HW   = 11,
  parameter int VW   = 10,
  parameter int N_HS = 2,
  parameter int N_LD = 4,
  parameter int N_FR = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [N_HS-1:0] hstart_o,
  output logic [N_LD-1:0] hload_o,
  output logic [N_FR-1:0] vframe_o,
  output logic            active_o
);

  localparam int NOUT = N_HS + N_LD + N_FR + 1;

  logic                    edge_sel, and_en, or_en;
  logic [HW-1:0]           hper, act_hs, act_he, hcnt;
  logic [VW-1:0]           vper, act_vs, act_ve, vcnt;
  logic [N_HS-1:0][HW-1:0] hs_pos;
  logic [N_HS-1:0]         hs_pol;
  logic [N_LD-1:0][HW-1:0] ld_lead, ld_trail;
  logic [N_LD-1:0]         ld_pol;
  logic [N_FR-1:0][VW-1:0] fr_lead, fr_trail;
  logic [N_FR-1:0]         fr_pol;

  ltg_regfile #(.HW(HW), .VW(VW), .N_HS(N_HS), .N_LD(N_LD), .N_FR(N_FR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .edge_sel(edge_sel), .and_en(and_en),
    .or_en(or_en), .hper(hper), .vper(vper), .act_hs(act_hs), .act_he(act_he),
    .act_vs(act_vs), .act_ve(act_ve), .hs_pos(hs_pos), .hs_pol(hs_pol),
    .ld_lead(ld_lead), .ld_trail(ld_trail), .ld_pol(ld_pol),
    .fr_lead(fr_lead), .fr_trail(fr_trail), .fr_pol(fr_pol)
  );

  ltg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hper(hper), .vper(vper), .hcnt(hcnt), .vcnt(vcnt)
  );

  logic [N_HS-1:0] hs_hit;
  logic [N_LD-1:0] ld_hit;
  logic [N_FR-1:0] fr_hit;
  logic [N_FR-1:0] fr_mix;

  for (genvar i = 0; i < N_HS; i++) begin : g_hs
    assign hs_hit[i] = (hcnt == hs_pos[i]);
  end

  for (genvar i = 0; i < N_LD; i++) begin : g_ld
    ltg_window #(.W(HW)) u_win (
      .cnt(hcnt), .lead(ld_lead[i]), .trail(ld_trail[i]), .hit(ld_hit[i])
    );
  end

  for (genvar i = 0; i < N_FR; i++) begin : g_fr
    ltg_window #(.W(VW)) u_win (
      .cnt(vcnt), .lead(fr_lead[i]), .trail(fr_trail[i]), .hit(fr_hit[i])
    );
    if (i == AND_FR) begin : g_and
      assign fr_mix[i] = and_en ? (fr_hit[i] & ld_hit[AND_LD]) : fr_hit[i];
    end else if (i == OR_FR) begin : g_or
      assign fr_mix[i] = or_en ? (fr_hit[i] | ld_hit[OR_LD]) : fr_hit[i];
    end else begin : g_plain
      assign fr_mix[i] = fr_hit[i];
    end
  end

  logic act_hit;
  assign act_hit = (hcnt >= act_hs) && (hcnt < act_he) &&
                   (vcnt >= act_vs) && (vcnt < act_ve);

  logic [NOUT-1:0] out_d, out_q;
  assign out_d = {act_hit, fr_mix ^ fr_pol, ld_hit ^ ld_pol, hs_hit ^ hs_pol};

  ltg_out_stage #(.N(NOUT)) u_out (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .d(out_d), .q(out_q)
  );

  assign hstart_o = out_q[N_HS-1:0];
  assign hload_o  = out_q[N_HS +: N_LD];
  assign vframe_o = out_q[N_HS+N_LD +: N_FR];
  assign active_o = out_q[NOUT-1];

  // R5: with an empty window the registered load output holds its idle level
  assert_empty_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_sel && $stable(ld_trail[0]) && $stable(ld_lead[0]) && $stable(ld_pol[0]) &&
     ld_trail[0] <= ld_lead[0]) |=> (hload_o[0] == ld_pol[0]));

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  localparam int HW = 11;
  localparam int VW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  hstart_o;
  logic [3:0]  hload_o;
  logic [2:0]  vframe_o;
  logic        active_o;

  always #5 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hstart_o(hstart_o), .hload_o(hload_o),
    .vframe_o(vframe_o), .active_o(active_o)
  );

  int checks = 0;
  int errors = 0;
  bit running = 0;

  // behavioural model state
  int ctrl, hper, vper, ahs, ahe, avs, ave;
  int hs_pos[2], hs_pol[2];
  int ld_l[4], ld_t[4], ld_p[4];
  int fr_l[3], fr_t[3], fr_p[3];
  int hc, vc;
  logic [9:0]  exp_cur, exp_prev;
  logic [15:0] exp_rd;

  function automatic logic [15:0] regval(int a);
    for (int i = 0; i < 2; i++) if (a == 8 + i) return 16'((hs_pol[i] << 15) | hs_pos[i]);
    for (int i = 0; i < 4; i++) begin
      if (a == 16 + 2*i) return 16'((ld_p[i] << 15) | ld_l[i]);
      if (a == 17 + 2*i) return 16'(ld_t[i]);
    end
    for (int i = 0; i < 3; i++) begin
      if (a == 32 + 2*i) return 16'((fr_p[i] << 15) | fr_l[i]);
      if (a == 33 + 2*i) return 16'(fr_t[i]);
    end
    case (a)
      0: return 16'(ctrl);
      1: return 16'(hper);
      2: return 16'(vper);
      3: return 16'(ahs);
      4: return 16'(ahe);
      5: return 16'(avs);
      6: return 16'(ave);
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [9:0] decode();
    logic [1:0] hs;
    logic [3:0] lh;
    logic [2:0] fh;
    logic       act;
    for (int i = 0; i < 2; i++) hs[i] = (hc == hs_pos[i]);
    for (int i = 0; i < 4; i++) lh[i] = (hc >= ld_l[i]) && (hc < ld_t[i]);
    for (int i = 0; i < 3; i++) fh[i] = (vc >= fr_l[i]) && (vc < fr_t[i]);
    if (ctrl[1]) fh[1] = fh[1] & lh[3];
    if (ctrl[2]) fh[2] = fh[2] | lh[1];
    for (int i = 0; i < 2; i++) hs[i] ^= hs_pol[i][0];
    for (int i = 0; i < 4; i++) lh[i] ^= ld_p[i][0];
    for (int i = 0; i < 3; i++) fh[i] ^= fr_p[i][0];
    act = (hc >= ahs) && (hc < ahe) && (vc >= avs) && (vc < ave);
    return {act, fh, lh, hs};
  endfunction

  task automatic apply_write(int a, int d);
    int p = (d >> 15) & 1;
    for (int i = 0; i < 2; i++) if (a == 8 + i) begin hs_pos[i] = d & 16'h7FF; hs_pol[i] = p; end
    for (int i = 0; i < 4; i++) begin
      if (a == 16 + 2*i) begin ld_l[i] = d & 16'h7FF; ld_p[i] = p; end
      if (a == 17 + 2*i) ld_t[i] = d & 16'h7FF;
    end
    for (int i = 0; i < 3; i++) begin
      if (a == 32 + 2*i) begin fr_l[i] = d & 16'h3FF; fr_p[i] = p; end
      if (a == 33 + 2*i) fr_t[i] = d & 16'h3FF;
    end
    case (a)
      0: ctrl = d & 7;
      1: hper = d & 16'h7FF;
      2: vper = d & 16'h3FF;
      3: ahs  = d & 16'h7FF;
      4: ahe  = d & 16'h7FF;
      5: avs  = d & 16'h3FF;
      6: ave  = d & 16'h3FF;
      default: ;
    endcase
  endtask

  task automatic model_reset();
    ctrl = 0; hper = 0; vper = 0; ahs = 0; ahe = 0; avs = 0; ave = 0;
    for (int i = 0; i < 2; i++) begin hs_pos[i] = 0; hs_pol[i] = 0; end
    for (int i = 0; i < 4; i++) begin ld_l[i] = 0; ld_t[i] = 0; ld_p[i] = 0; end
    for (int i = 0; i < 3; i++) begin fr_l[i] = 0; fr_t[i] = 0; fr_p[i] = 0; end
    hc = 0; vc = 0; exp_cur = '0; exp_prev = '0; exp_rd = '0;
  endtask

  // R2/R3 counter rules are carried by the model and checked via every strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int hl, vl;
      exp_prev = exp_cur;
      exp_cur  = decode();
      exp_rd   = regval(int'(rd_addr));
      if (wr_en) apply_write(int'(wr_addr), int'(wr_data));
      hl = (hper == 0) ? (1 << HW) - 1 : hper - 1;
      vl = (vper == 0) ? (1 << VW) - 1 : vper - 1;
      if (hc >= hl) begin
        hc = 0;
        vc = (vc >= vl) ? 0 : vc + 1;
      end else hc = hc + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (running && rst_n) begin
      logic [9:0] e;
      e = ctrl[0] ? exp_prev : exp_cur;  // R11 falling-edge copy lags half a cycle
      chk(ctrl[0] ? "R11/R4 hstart" : "R4/R7 hstart", int'(hstart_o), int'(e[1:0]));
      chk("R5/R7 hload", int'(hload_o), int'(e[5:2]));
      chk("R6/R8/R9 vframe", int'(vframe_o), int'(e[8:6]));
      chk("R10 active", int'(active_o), int'(e[9]));
      chk("R1 readback", int'(rd_data), int'(exp_rd));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R12 reset state
    chk("R12 reset outputs", int'({active_o, vframe_o, hload_o, hstart_o}), 0);
    chk("R12 reset rd_data", int'(rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    wr(1, 20); wr(2, 6);
    wr(8, 3); wr(9, 16'h8000 | 15);
    wr(16, 2);  wr(17, 8);
    wr(18, 16'h8000 | 5); wr(19, 12);
    wr(20, 10); wr(21, 10);           // R5 empty window
    wr(22, 0);  wr(23, 19);
    wr(32, 1);  wr(33, 3);
    wr(34, 0);  wr(35, 4);
    wr(36, 16'h8000 | 4); wr(37, 6);
    wr(3, 4); wr(4, 16); wr(5, 1); wr(6, 5);
    repeat (300) @(posedge clk);
    wr(0, 2);                          // R8 AND merge
    repeat (300) @(posedge clk);
    wr(0, 6);                          // R9 OR merge too
    repeat (300) @(posedge clk);
    wr(0, 7);                          // R11 falling-edge launch
    repeat (300) @(posedge clk);
    wr(0, 6);
    repeat (13) @(posedge clk);
    wr(1, 5);                          // R2 shrink mid-line
    repeat (100) @(posedge clk);
    wr(2, 1);                          // R3 one-line frame
    repeat (50) @(posedge clk);
    wr(50, 16'h1234);                  // R1 unmapped write dropped
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
    end
    repeat (3) @(posedge clk);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule